// File: doc/BRIEF.md
# Cascaded Shift-Driver Load Sequencer

This block feeds a frame of display data into a chain of serial-in, parallel-out high-voltage driver registers. Each register in the chain samples its serial input on the falling edge of its own clock line. A client presents a parallel frame word and pulses a start strobe. The block then sends the frame one bit at a time on a single serial data line and toggles one clock line per chained register. When every bit has been sent, it pulses a latch-enable line that moves the shifted contents onto the driver outputs.

Every bit has a high phase and a low phase, each lasting a programmable number of system clock cycles. The default is 500 cycles, which is 5 us at 100 MHz. The per-stage clock lines all rise together. They fall one after another, starting at the far end of the chain and moving towards the near end, with a programmable gap between falls. Because of this order, a register always samples its upstream neighbour's output before that neighbour shifts, so skew between chained registers cannot make a bit go missing.

Top module: `cascade_load_seq`

## Requirements
- R1: After reset, all clock lines, latch-enable, the data line and busy are low.
- R2: A start strobe seen while idle captures the frame word. On the next edge, busy goes high and all clock lines go high.
- R3: The frame's most significant bit is sent first. The chain here has stage 0 fed from the data line and stage 1 fed from stage 0's top bit, each register 32 bits wide. After latching, stage 1 holds frame bits 63..32 and stage 0 holds bits 31..0.
- R4: For every bit, all clock lines stay high for PHASE_CYC cycles while the bit is on the data line.
- R5: At most one clock line falls per cycle. The falls go from the highest-numbered stage down to stage 0.
- R6: Successive clock falls within one bit are SKEW_CYC cycles apart.
- R7: The data line changes only in the cycle the clock lines rise. It stays constant while any clock line is high and through the low hold that follows.
- R8: After the stage 0 clock falls, all clock lines stay low for PHASE_CYC cycles before the next bit begins.
- R9: After the low hold of the final bit, latch-enable is high for PHASE_CYC cycles. During that time all clock lines and the data line are low.
- R10: Busy stays high from the cycle after the accepted strobe until latch-enable falls. A strobe that arrives while busy is ignored, including one in the last latch cycle.
- R11: While idle, the data line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start strobe for one frame |
| frame_i | input | STAGES*STAGE_W | Frame word, sampled when a strobe is accepted |
| sdata_o | output | 1 | Serial data to the first register of the chain |
| sclk_o | output | STAGES | One shift clock per chained register, index 0 nearest |
| latch_o | output | 1 | Latch-enable pulse after the frame |
| busy_o | output | 1 | High while a frame is in progress |

## Verification
The bench runs a short phase count and a stagger different from it, so that a design mixing up the two counts would put the second fall in the wrong cycle. A behavioural model of the two chained registers samples on the falling clock edges. If the fall order were reversed, that model would lose bits and end up with shifted contents in stage 1. Start strobes are sent in the middle of a frame and held high through the final latch cycle. A design that restarted early would show up as a changed latched frame or a busy line that never drops. MSB-first ordering is tested with asymmetric patterns, because a reversed order would give a mirrored result.

// File: rtl/cls_pkg.sv
package cls_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HIGH,
    ST_FALL,
    ST_LOW,
    ST_LATCH
  } seq_state_t;
endpackage

// File: rtl/cls_phase_timer.sv
module cls_phase_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] value_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)            cnt_d = value_i;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/cls_frame_reg.sv
module cls_frame_reg #(
  parameter int FRAME_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               shift_i,
  input  logic               clear_i,
  output logic               msb_o
);
  logic [FRAME_W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (clear_i)      sr_d = '0;
    else if (load_i)  sr_d = frame_i;
    else if (shift_i) sr_d = {sr_q[FRAME_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign msb_o = sr_q[FRAME_W-1];
endmodule

// File: rtl/cls_clk_lines.sv
module cls_clk_lines #(
  parameter int STAGES = 2,
  parameter int IDX_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_all_i,
  input  logic              drop_i,
  input  logic [IDX_W-1:0]  drop_idx_i,
  output logic [STAGES-1:0] sclk_o
);
  for (genvar g = 0; g < STAGES; g++) begin : g_line
    logic line_q, line_d;
    always_comb begin
      line_d = line_q;
      if (set_all_i)                                line_d = 1'b1;
      else if (drop_i && drop_idx_i == IDX_W'(g))   line_d = 1'b0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q <= 1'b0;
      else        line_q <= line_d;
    end
    assign sclk_o[g] = line_q;
  end
endmodule

// File: rtl/cascade_load_seq.sv
module cascade_load_seq
  import cls_pkg::*;
#(
  parameter int STAGES    = 2,
  parameter int STAGE_W   = 32,
  parameter int PHASE_CYC = 500,
  parameter int SKEW_CYC  = PHASE_CYC
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic [STAGES*STAGE_W-1:0]   frame_i,
  output logic                        sdata_o,
  output logic [STAGES-1:0]           sclk_o,
  output logic                        latch_o,
  output logic                        busy_o
);
  localparam int FRAME_W  = STAGES * STAGE_W;
  localparam int BIT_W    = $clog2(FRAME_W);
  localparam int MAX_CYC  = (PHASE_CYC > SKEW_CYC) ? PHASE_CYC : SKEW_CYC;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);
  localparam int IDX_W    = (STAGES > 1) ? $clog2(STAGES) : 1;
  localparam logic [CNT_W-1:0] PH_LD  = CNT_W'(PHASE_CYC - 1);
  localparam logic [CNT_W-1:0] SK_LD  = CNT_W'(SKEW_CYC - 1);
  localparam logic [IDX_W-1:0] FAR_IX = IDX_W'(STAGES - 1);
  localparam logic [IDX_W-1:0] NXT_IX = IDX_W'((STAGES > 1) ? STAGES - 2 : 0);
  localparam logic [BIT_W-1:0] LAST_B = BIT_W'(FRAME_W - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  seq_state_t       state_q, state_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             le_q, le_d;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic             sr_load, sr_shift, sr_clear;
  logic             clk_set, clk_drop;
  logic [IDX_W-1:0] drop_idx;

  always_comb begin
    state_d  = state_q;
    bit_d    = bit_q;
    idx_d    = idx_q;
    le_d     = le_q;
    tmr_load = 1'b0;
    tmr_val  = PH_LD;
    sr_load  = 1'b0;
    sr_shift = 1'b0;
    sr_clear = 1'b0;
    clk_set  = 1'b0;
    clk_drop = 1'b0;
    drop_idx = (state_q == ST_HIGH) ? FAR_IX : idx_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d  = ST_HIGH;
        sr_load  = 1'b1;
        clk_set  = 1'b1;
        bit_d    = '0;
        tmr_load = 1'b1;
      end
      ST_HIGH: if (tmr_zero) begin
        clk_drop = 1'b1;
        tmr_load = 1'b1;
        if (STAGES > 1) begin
          state_d = ST_FALL;
          idx_d   = NXT_IX;
          tmr_val = SK_LD;
        end else begin
          state_d = ST_LOW;
        end
      end
      ST_FALL: if (tmr_zero) begin
        clk_drop = 1'b1;
        tmr_load = 1'b1;
        if (idx_q == '0) begin
          state_d = ST_LOW;
        end else begin
          idx_d   = idx_q - 1'b1;
          tmr_val = SK_LD;
        end
      end
      ST_LOW: if (tmr_zero) begin
        tmr_load = 1'b1;
        if (bit_q == LAST_B) begin
          state_d  = ST_LATCH;
          sr_clear = 1'b1;
          le_d     = 1'b1;
        end else begin
          state_d  = ST_HIGH;
          sr_shift = 1'b1;
          clk_set  = 1'b1;
          bit_d    = bit_q + 1'b1;
        end
      end
      ST_LATCH: if (tmr_zero) begin
        state_d = ST_IDLE;
        le_d    = 1'b0;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      idx_q   <= '0;
      le_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      idx_q   <= idx_d;
      le_q    <= le_d;
    end
  end

  cls_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_s_n), .load_i(tmr_load), .value_i(tmr_val),
    .zero_o(tmr_zero)
  );

  cls_frame_reg #(.FRAME_W(FRAME_W)) u_frame (
    .clk(clk), .rst_n(rst_s_n), .load_i(sr_load), .frame_i(frame_i),
    .shift_i(sr_shift), .clear_i(sr_clear), .msb_o(sdata_o)
  );

  cls_clk_lines #(.STAGES(STAGES), .IDX_W(IDX_W)) u_lines (
    .clk(clk), .rst_n(rst_s_n), .set_all_i(clk_set), .drop_i(clk_drop),
    .drop_idx_i(drop_idx), .sclk_o(sclk_o)
  );

  assign latch_o = le_q;
  assign busy_o  = (state_q != ST_IDLE);

  // R2: an accepted strobe raises every clock line and busy
  a_r2_start_raises: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == ST_IDLE && start_i) |=> (&sclk_o && busy_o));

  // R5: never two clock lines falling in the same cycle
  a_r5_single_fall: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0($past(sclk_o) & ~sclk_o));

  // R5: a line may only fall once its downstream neighbour is already low
  for (genvar s = 0; s < STAGES - 1; s++) begin : g_order
    a_r5_downstream_first: assert property (@(posedge clk) disable iff (!rst_s_n)
      $fell(sclk_o[s]) |-> !sclk_o[s+1]);
  end

  // R7: serial data frozen while any clock line was high
  a_r7_data_stable: assert property (@(posedge clk) disable iff (!rst_s_n)
    (|$past(sclk_o)) |-> $stable(sdata_o));

  // R9: during the latch pulse the shift lines are quiet
  a_r9_latch_quiet: assert property (@(posedge clk) disable iff (!rst_s_n)
    latch_o |-> (sclk_o == '0 && !sdata_o));

  // R10: busy only drops together with latch-enable
  a_r10_busy_ends_at_latch: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(busy_o) |-> ($past(latch_o) && !latch_o));

  // R10: a strobe in the final latch cycle does not restart
  a_r10_late_start_ignored: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == ST_LATCH && tmr_zero && start_i) |=> !busy_o);

  // R11: idle means every output line low
  a_r11_idle_low: assert property (@(posedge clk) disable iff (!rst_s_n)
    !busy_o |-> (!sdata_o && sclk_o == '0 && !latch_o));
endmodule

// File: tb/tb_cascade_load_seq.sv
module tb_cascade_load_seq;
  localparam int S  = 2;
  localparam int W  = 32;
  localparam int F  = S * W;
  localparam int P  = 4;
  localparam int K  = 2;

  typedef struct packed {
    logic [S-1:0] c;
    logic         d;
    logic         l;
    logic         b;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i;
  logic [F-1:0] frame_i;
  logic         sdata_o;
  logic [S-1:0] sclk_o;
  logic         latch_o;
  logic         busy_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cascade_load_seq #(.STAGES(S), .STAGE_W(W), .PHASE_CYC(P), .SKEW_CYC(K)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .frame_i(frame_i),
    .sdata_o(sdata_o), .sclk_o(sclk_o), .latch_o(latch_o), .busy_o(busy_o)
  );

  // behavioural reference: list of expected output states, one per cycle
  exp_t         q[$];
  exp_t         exp_s;
  logic [F-1:0] accepted[$];

  task automatic build(input logic [F-1:0] fr);
    for (int i = F - 1; i >= 0; i--) begin
      logic [S-1:0] m;
      m = '1;
      for (int n = 0; n < P; n++) q.push_back('{m, fr[i], 1'b0, 1'b1});
      for (int j = 1; j < S; j++) begin
        m[S-j] = 1'b0;
        for (int n = 0; n < K; n++) q.push_back('{m, fr[i], 1'b0, 1'b1});
      end
      for (int n = 0; n < P; n++) q.push_back('{'0, fr[i], 1'b0, 1'b1});
    end
    for (int n = 0; n < P; n++) q.push_back('{'0, 1'b0, 1'b1, 1'b1});
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      exp_s = '0;
    end else begin
      if (q.size() == 0 && !exp_s.b && start_i) begin
        build(frame_i);
        accepted.push_back(frame_i);
      end
      if (q.size() > 0) exp_s = q.pop_front();
      else              exp_s = '0;
    end
  end

  task automatic chk(input string req, input logic [F-1:0] act, input logic [F-1:0] want);
    checks++;
    if (act !== want) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, want, $time);
    end
  endtask

  // per-cycle comparison plus a falling-edge model of the driver chain
  logic [W-1:0] reg0 = '0, reg1 = '0;
  logic [S-1:0] sclk_prev = '0;
  logic         le_prev = 1'b0;
  bit           run_cmp = 1'b0;

  always @(negedge clk) begin
    if (run_cmp) begin
      chk("R4 R5 R6 R8 clock lines", F'(sclk_o), F'(exp_s.c));
      chk("R3 R7 R11 data line", F'(sdata_o), F'(exp_s.d));
      chk("R9 latch", F'(latch_o), F'(exp_s.l));
      chk("R2 R10 busy", F'(busy_o), F'(exp_s.b));
      if (sclk_prev[1] && !sclk_o[1]) reg1 = {reg1[W-2:0], reg0[W-1]};
      if (sclk_prev[0] && !sclk_o[0]) reg0 = {reg0[W-2:0], sdata_o};
      if (le_prev && !latch_o) begin
        if (accepted.size() > 0) chk("R3 R10 latched frame", {reg1, reg0}, accepted.pop_front());
        else chk("R10 unexpected latch", 1, 0);
      end
    end
    sclk_prev = sclk_o;
    le_prev   = latch_o;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy_o) @(negedge clk);
  endtask

  task automatic pulse(input logic [F-1:0] fr);
    @(negedge clk);
    start_i = 1'b1;
    frame_i = fr;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  initial begin
    rst_n   = 1'b0;
    start_i = 1'b0;
    frame_i = '0;
    repeat (5) @(negedge clk);
    // R1: outputs low in reset
    chk("R1 reset outputs", F'({sdata_o, sclk_o, latch_o, busy_o}), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", F'({sdata_o, sclk_o, latch_o, busy_o}), '0);
    run_cmp = 1'b1;

    // asymmetric frame, then an ignored strobe mid-frame (R10)
    pulse(64'hF0E1_D2C3_0011_8001);
    repeat (120) @(negedge clk);
    pulse(64'h1234_5678_9ABC_DEF0);
    wait_idle();
    chk("R10 no restart after ignored strobe", F'(busy_o), '0);

    // strobe held high: last latch cycle ignores it, idle accepts it
    @(negedge clk);
    start_i = 1'b1;
    frame_i = 64'hAAAA_5555_0000_FFFF;
    @(negedge clk);
    frame_i = 64'h8000_0000_0000_0001;
    while (!latch_o) @(negedge clk);
    while (latch_o) @(negedge clk);
    @(negedge clk);
    start_i = 1'b0;
    wait_idle();

    pulse('1);
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R11 idle data low", F'(sdata_o), '0);
    chk("R3 all frames latched", F'(accepted.size()), '0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule